// File: doc/BRIEF.md
# Split-Tag Direct-Mapped Translation Cache

This block caches virtual-to-physical translations for a processor's fast path. It is direct-mapped. It holds one translation data word per slot and three separate tag banks, one for each access class: instruction fetch, data load and data store. A lookup presents a virtual address and an access class. One cycle later the block reports whether that class's tag matched, together with the stored translation word.

After a page walk, the slow path installs a translation through the refill port. The new page number goes only into the bank of the refilling class. Tags of the other two classes at the same slot survive only if they name the same page. Any other tag in that slot is evicted, because the shared data word has just been overwritten.

Each access class has its own trigger-watch enable. When that enable is set at refill time, a marker bit above the page number is folded into the written tag. Lookups compare the marker too, so a marked entry always misses and sends the access to the slow path. A flush input invalidates every tag in one cycle.

Top module: `split_tlb`

## Requirements
- R1: After reset every lookup of every class misses, and the response outputs are all zero until the first lookup response.
- R2: The slot is chosen by the low log2(ENTRIES) bits of the virtual page number (address bits from PG_SHIFT upward). The page-offset bits have no effect on a lookup.
- R3: A lookup with lk_valid raises rsp_valid exactly one cycle later. rsp_hit is 1 only when the selected class's tag at the slot equals the full virtual page number with the marker clear. On a hit rsp_data is the slot's data word; on a miss it is zero.
- R4: A refill (class codes: 0 fetch, 1 load, 2 store) writes the tag only into the bank of its own class. A tag of another class at that slot that names the same page keeps hitting.
- R5: A refill sets to all ones (invalid) every tag of the other classes at that slot whose page number differs from the refilled one, ignoring the marker bit.
- R6: When trig_en[class] is set during a refill, the tag is written with the marker bit (bit above the page number) set, and lookups of that page by that class miss. A later refill with the enable clear makes it hit again.
- R7: A flush invalidates every slot of all three tag banks.
- R8: A flush and a refill in the same cycle leave every tag invalid. The refill is dropped entirely.
- R9: A lookup in the same cycle as a refill or flush sees the contents from before that cycle's update.
- R10: Class code 3 is reserved. A lookup with it always misses, and a refill with it changes no tag and no data word.
- R11: All three classes share one data word per slot. A refill of any class replaces the word returned by hits of the other classes that still hold the same page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Invalidate all tags |
| trig_en | input | 3 | Per-class trigger-watch enable (bit 0 fetch, 1 load, 2 store) |
| lk_valid | input | 1 | Lookup request |
| lk_type | input | 2 | Lookup access class |
| lk_vaddr | input | VA_W | Lookup virtual address |
| rf_valid | input | 1 | Refill request |
| rf_type | input | 2 | Refill access class |
| rf_vaddr | input | VA_W | Refill virtual address |
| rf_data | input | DATA_W | Translation word to store |
| rsp_valid | output | 1 | Lookup response valid |
| rsp_hit | output | 1 | Lookup hit |
| rsp_data | output | DATA_W | Translation word on hit, zero on miss |

## Verification
A lookup can fall in the same cycle as a refill to the same slot, and a refill can coincide with a flush. The bench provokes both: directed cycles pair a lookup with a refill of the same page, and a flush with a fetch refill. Random traffic also issues refills, lookups and occasional flushes back to back on a small pool of colliding pages. Each response is judged against a bench model that computes the lookup from the state before the cycle's update. The model then applies the flush in preference to the refill.

// File: rtl/split_tlb_pkg.sv
package split_tlb_pkg;
   localparam int NUM_CLASSES = 3;

   typedef enum logic [1:0] {
      CLS_FETCH = 2'd0,
      CLS_LOAD  = 2'd1,
      CLS_STORE = 2'd2,
      CLS_RSVD  = 2'd3
   } acc_class_e;

   function automatic logic class_is_real(input logic [1:0] c);
      return c != CLS_RSVD;
   endfunction
endpackage

// File: rtl/split_tlb_tag_bank.sv
module split_tlb_tag_bank #(
   parameter int VPN_W = 20,
   parameter int ENTRIES = 16,
   localparam int IDX_W = $clog2(ENTRIES),
   localparam int TAG_W = VPN_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             fill_go,
   input  logic             fill_own,
   input  logic             fill_mark,
   input  logic [IDX_W-1:0] fill_idx,
   input  logic [VPN_W-1:0] fill_vpn,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [TAG_W-1:0] rd_tag
);
   logic [TAG_W-1:0] tag_q [ENTRIES];
   logic             same_page;

   assign same_page = tag_q[fill_idx][VPN_W-1:0] == fill_vpn;
   assign rd_tag    = tag_q[rd_idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < ENTRIES; i++) tag_q[i] <= '1;
      end else if (flush) begin
         for (int i = 0; i < ENTRIES; i++) tag_q[i] <= '1;
      end else if (fill_go) begin
         if (fill_own)
            tag_q[fill_idx] <= {fill_mark, fill_vpn};
         else if (!same_page)
            tag_q[fill_idx] <= '1;
      end
   end
endmodule

// File: rtl/split_tlb_data_bank.sv
module split_tlb_data_bank #(
   parameter int DATA_W = 32,
   parameter int ENTRIES = 16,
   localparam int IDX_W = $clog2(ENTRIES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_word,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_word
);
   logic [DATA_W-1:0] word_q [ENTRIES];

   assign rd_word = word_q[rd_idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < ENTRIES; i++) word_q[i] <= '0;
      end else if (wr_en) begin
         word_q[wr_idx] <= wr_word;
      end
   end
endmodule

// File: rtl/split_tlb.sv
module split_tlb
   import split_tlb_pkg::*;
#(
   parameter int VA_W = 32,
   parameter int PG_SHIFT = 12,
   parameter int ENTRIES = 16,
   parameter int DATA_W = 32,
   localparam int VPN_W = VA_W - PG_SHIFT,
   localparam int IDX_W = $clog2(ENTRIES),
   localparam int TAG_W = VPN_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic [2:0]        trig_en,
   input  logic              lk_valid,
   input  logic [1:0]        lk_type,
   input  logic [VA_W-1:0]   lk_vaddr,
   input  logic              rf_valid,
   input  logic [1:0]        rf_type,
   input  logic [VA_W-1:0]   rf_vaddr,
   input  logic [DATA_W-1:0] rf_data,
   output logic              rsp_valid,
   output logic              rsp_hit,
   output logic [DATA_W-1:0] rsp_data
);
   if (ENTRIES < 2 || (1 << IDX_W) != ENTRIES) begin : g_bad_entries
      $error("split_tlb: ENTRIES must be a power of two of at least 2");
   end
   if (PG_SHIFT < 1 || VPN_W < IDX_W) begin : g_bad_split
      $error("split_tlb: page number narrower than the slot index");
   end

   logic [VPN_W-1:0]  lk_vpn, rf_vpn;
   logic [IDX_W-1:0]  lk_idx, rf_idx;
   logic              fill_go;
   logic [TAG_W-1:0]  bank_tag [NUM_CLASSES];
   logic [NUM_CLASSES-1:0] bank_match;
   logic [DATA_W-1:0] slot_word;
   logic              hit_d;
   logic              unused_offsets;

   assign lk_vpn  = lk_vaddr[VA_W-1:PG_SHIFT];
   assign rf_vpn  = rf_vaddr[VA_W-1:PG_SHIFT];
   assign lk_idx  = lk_vpn[IDX_W-1:0];
   assign rf_idx  = rf_vpn[IDX_W-1:0];
   assign fill_go = rf_valid && class_is_real(rf_type);
   assign unused_offsets = ^{lk_vaddr[PG_SHIFT-1:0], rf_vaddr[PG_SHIFT-1:0]};

   for (genvar g = 0; g < NUM_CLASSES; g++) begin : g_bank
      split_tlb_tag_bank #(
         .VPN_W  (VPN_W),
         .ENTRIES(ENTRIES)
      ) tag_i (
         .clk      (clk),
         .rst_n    (rst_n),
         .flush    (flush),
         .fill_go  (fill_go),
         .fill_own (rf_type == 2'(g)),
         .fill_mark(trig_en[g]),
         .fill_idx (rf_idx),
         .fill_vpn (rf_vpn),
         .rd_idx   (lk_idx),
         .rd_tag   (bank_tag[g])
      );
      assign bank_match[g] = (lk_type == 2'(g)) && (bank_tag[g] == {1'b0, lk_vpn});
   end

   split_tlb_data_bank #(
      .DATA_W (DATA_W),
      .ENTRIES(ENTRIES)
   ) data_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (fill_go && !flush),
      .wr_idx (rf_idx),
      .wr_word(rf_data),
      .rd_idx (lk_idx),
      .rd_word(slot_word)
   );

   assign hit_d = lk_valid && (|bank_match);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_hit   <= 1'b0;
         rsp_data  <= '0;
      end else begin
         rsp_valid <= lk_valid;
         rsp_hit   <= hit_d;
         rsp_data  <= hit_d ? slot_word : '0;
      end
   end
endmodule

// File: rtl/split_tlb_chk.sv
module split_tlb_chk #(
   parameter int VA_W = 32,
   parameter int PG_SHIFT = 12,
   parameter int ENTRIES = 16,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              flush,
   input logic [2:0]        trig_en,
   input logic              lk_valid,
   input logic [1:0]        lk_type,
   input logic [VA_W-1:0]   lk_vaddr,
   input logic              rf_valid,
   input logic [1:0]        rf_type,
   input logic [VA_W-1:0]   rf_vaddr,
   input logic [DATA_W-1:0] rf_data,
   input logic              rsp_valid,
   input logic              rsp_hit,
   input logic [DATA_W-1:0] rsp_data
);
   logic real_fill, marked_fill;
   logic [VA_W-PG_SHIFT-1:0] lk_pg, rf_pg;

   assign lk_pg       = lk_vaddr[VA_W-1:PG_SHIFT];
   assign rf_pg       = rf_vaddr[VA_W-1:PG_SHIFT];
   assign real_fill   = rf_valid && rf_type != 2'd3;
   assign marked_fill = real_fill && ((rf_type == 2'd0 && trig_en[0]) ||
                                      (rf_type == 2'd1 && trig_en[1]) ||
                                      (rf_type == 2'd2 && trig_en[2]));

   a_r3_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> rsp_valid);
   a_r3_rsp_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |=> !rsp_valid && !rsp_hit);
   a_r3_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_hit) |-> rsp_data == '0);
   a_r4_fill_then_hit: assert property (@(posedge clk) disable iff (!rst_n)
      (real_fill && !marked_fill && !flush) ##1
      (lk_valid && lk_type == $past(rf_type) && lk_pg == $past(rf_pg))
      |=> rsp_hit && rsp_data == $past(rf_data, 2));
   a_r6_marked_miss: assert property (@(posedge clk) disable iff (!rst_n)
      marked_fill ##1
      (lk_valid && lk_type == $past(rf_type) && lk_pg == $past(rf_pg))
      |=> !rsp_hit);
   a_r7_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
      flush ##1 lk_valid |=> !rsp_hit);
   a_r10_rsvd_miss: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid && lk_type == 2'd3) |=> !rsp_hit);
endmodule

bind split_tlb split_tlb_chk #(
   .VA_W    (VA_W),
   .PG_SHIFT(PG_SHIFT),
   .ENTRIES (ENTRIES),
   .DATA_W  (DATA_W)
) chk_i (.*);

// File: tb/split_tlb_tb_top.sv
module split_tlb_tb_top;
   localparam int VA_W = 32;
   localparam int PG_SHIFT = 12;
   localparam int ENTRIES = 16;
   localparam int DATA_W = 32;
   localparam int VPN_W = VA_W - PG_SHIFT;
   localparam int TAG_W = VPN_W + 1;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              flush = 1'b0;
   logic [2:0]        trig_en = '0;
   logic              lk_valid = 1'b0;
   logic [1:0]        lk_type = '0;
   logic [VA_W-1:0]   lk_vaddr = '0;
   logic              rf_valid = 1'b0;
   logic [1:0]        rf_type = '0;
   logic [VA_W-1:0]   rf_vaddr = '0;
   logic [DATA_W-1:0] rf_data = '0;
   logic              rsp_valid, rsp_hit;
   logic [DATA_W-1:0] rsp_data;

   always #5 clk = ~clk;

   split_tlb #(.VA_W(VA_W), .PG_SHIFT(PG_SHIFT), .ENTRIES(ENTRIES), .DATA_W(DATA_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .flush(flush), .trig_en(trig_en),
      .lk_valid(lk_valid), .lk_type(lk_type), .lk_vaddr(lk_vaddr),
      .rf_valid(rf_valid), .rf_type(rf_type), .rf_vaddr(rf_vaddr), .rf_data(rf_data),
      .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_data(rsp_data));

   // bench model
   logic [TAG_W-1:0]  m_tag [3][ENTRIES];
   logic [DATA_W-1:0] m_word [ENTRIES];
   int    n_vec = 0, n_bad = 0;
   bit    pend = 0;
   bit    e_v, e_h;
   logic [DATA_W-1:0] e_d;
   string e_req;

   function automatic logic [VA_W-1:0] mk_va(input logic [VPN_W-1:0] vpn, input logic [PG_SHIFT-1:0] off);
      return {vpn, off};
   endfunction

   function automatic int slot_of(input logic [VA_W-1:0] va);
      return int'(va[PG_SHIFT +: $clog2(ENTRIES)]);
   endfunction

   task automatic judge();
      n_vec++;
      if (rsp_valid !== e_v || rsp_hit !== e_h || rsp_data !== e_d) begin
         n_bad++;
         $display("FAIL %s: got v=%0b h=%0b d=%h expected v=%0b h=%0b d=%h",
                  e_req, rsp_valid, rsp_hit, rsp_data, e_v, e_h, e_d);
      end
   endtask

   task automatic step(input bit lkv, input logic [1:0] lkt, input logic [VA_W-1:0] lka,
                       input bit rfv, input logic [1:0] rft, input logic [VA_W-1:0] rfa,
                       input logic [DATA_W-1:0] rfd, input bit fl, input logic [2:0] trg,
                       input string req);
      int li, ri;
      logic [VPN_W-1:0] lv, rv;
      @(negedge clk);
      if (pend) judge();
      li = slot_of(lka); ri = slot_of(rfa);
      lv = lka[VA_W-1:PG_SHIFT]; rv = rfa[VA_W-1:PG_SHIFT];
      e_v = lkv;
      e_h = lkv && lkt != 2'd3 && m_tag[lkt][li] == {1'b0, lv};
      e_d = e_h ? m_word[li] : '0;
      e_req = req;
      pend = 1;
      if (fl) begin
         for (int c = 0; c < 3; c++)
            for (int i = 0; i < ENTRIES; i++) m_tag[c][i] = '1;
      end else if (rfv && rft != 2'd3) begin
         for (int c = 0; c < 3; c++) begin
            if (c == int'(rft)) m_tag[c][ri] = {trg[c], rv};
            else if (m_tag[c][ri][VPN_W-1:0] != rv) m_tag[c][ri] = '1;
         end
         m_word[ri] = rfd;
      end
      lk_valid = lkv; lk_type = lkt; lk_vaddr = lka;
      rf_valid = rfv; rf_type = rft; rf_vaddr = rfa; rf_data = rfd;
      flush = fl; trig_en = trg;
   endtask

   task automatic look(input logic [1:0] t, input logic [VA_W-1:0] a, input string req);
      step(1, t, a, 0, 0, 0, 0, 0, 0, req);
   endtask

   task automatic fill(input logic [1:0] t, input logic [VA_W-1:0] a, input logic [DATA_W-1:0] d,
                       input logic [2:0] trg);
      step(0, 0, 0, 1, t, a, d, 0, trg, "fill");
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: got running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      logic [VA_W-1:0] pa, pb, pc, pe, pf, pg, ph;
      void'($urandom(32'd4711));
      for (int c = 0; c < 3; c++)
         for (int i = 0; i < ENTRIES; i++) m_tag[c][i] = '1;
      for (int i = 0; i < ENTRIES; i++) m_word[i] = '0;
      pa = mk_va(20'h00123, 12'h010); pb = mk_va(20'h00213, 12'h020);
      pc = mk_va(20'h00457, 12'h000); pe = mk_va(20'h0055A, 12'h004);
      pf = mk_va(20'h0066B, 12'h008); pg = mk_va(20'h0077C, 12'h00C);
      ph = mk_va(20'h0088C, 12'h000);
      repeat (3) @(negedge clk);
      // R1: reset state of the outputs
      n_vec++;
      if (rsp_valid !== 1'b0 || rsp_hit !== 1'b0 || rsp_data !== '0) begin
         n_bad++;
         $display("FAIL R1: got v=%0b h=%0b d=%h expected 0 0 0", rsp_valid, rsp_hit, rsp_data);
      end
      rst_n = 1'b1;
      look(0, pa, "R1"); look(1, pa, "R1"); look(2, pb, "R1");
      // R3 basic hit and misses
      fill(1, pa, 32'hA000_0001, 3'b000);
      look(1, pa, "R3");
      look(1, mk_va(20'h00133, 12'h010), "R3");
      look(0, pa, "R4");
      // R2 offset ignored, other slot undisturbed
      look(1, mk_va(20'h00123, 12'hFFF), "R2");
      fill(2, mk_va(20'h00124, 12'h0), 32'hB0B0_0004, 3'b000);
      look(1, pa, "R2");
      // R11 / R4 shared word, same-page tag kept
      fill(0, pa, 32'hD200_0002, 3'b000);
      look(0, pa, "R11");
      look(1, pa, "R4");
      // R5 eviction of other classes
      fill(2, pb, 32'hE300_0003, 3'b000);
      look(1, pa, "R5"); look(0, pa, "R5"); look(2, pb, "R5");
      // R6 marker
      fill(1, pc, 32'hC000_0007, 3'b010);
      look(1, pc, "R6");
      fill(1, pc, 32'hC100_0007, 3'b000);
      look(1, pc, "R6");
      // R9 same-cycle lookup and refill
      step(1, 1, pe, 1, 1, pe, 32'h5555_000A, 0, 0, "R9");
      look(1, pe, "R9");
      // R8 flush with refill
      step(0, 0, 0, 1, 0, pf, 32'h6666_000B, 1, 0, "fill");
      look(0, pf, "R8");
      // R7 flush all classes
      fill(0, pa, 32'h1, 0); fill(1, pc, 32'h2, 0); fill(2, pe, 32'h3, 0);
      look(1, pc, "R7");
      step(0, 0, 0, 0, 0, 0, 0, 1, 0, "fill");
      look(0, pa, "R7"); look(1, pc, "R7"); look(2, pe, "R7");
      // R10 reserved class
      fill(1, pg, 32'h7777_000C, 0);
      fill(3, pg, 32'hDEAD_000C, 0);
      look(1, pg, "R10");
      fill(3, ph, 32'hDEAD_0001, 0);
      look(1, pg, "R10");
      look(3, pg, "R10");
      // random traffic (R3)
      for (int n = 0; n < 3000; n++) begin
         logic [3:0] ix, jx;
         logic [VPN_W-1:0] v1, v2;
         ix = 4'($urandom); jx = 4'($urandom);
         v1 = ($urandom % 5 == 0) ? {16'hFFFF, ix} : {16'($urandom % 3), ix};
         v2 = ($urandom % 5 == 0) ? {16'hFFFF, jx} : {16'($urandom % 3), jx};
         step($urandom % 3 != 0, 2'($urandom), mk_va(v1, 12'($urandom)),
              $urandom % 2 == 0, 2'($urandom), mk_va(v2, 12'($urandom)), $urandom,
              $urandom % 60 == 0, ($urandom % 4 == 0) ? 3'($urandom) : 3'b000, "R3");
      end
      step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R3");
      @(negedge clk);
      judge();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule